// File: doc/BRIEF.md
# SD Host Interrupt Status and Enable Registers

This block holds the interrupt registers of an SD host controller. Single-cycle event pulses come in from the command path, the data path and the card-detect logic. Each pulse is kept in a status bit only when the matching bit of a status-enable register is set. Software acknowledges events by writing ones to the status registers, which clears those bits.

A second pair of enable registers decides which of the kept bits drive the single level-sensitive interrupt line. The card's own interrupt request works differently: it is a level, not a pulse. It is mirrored into the normal status register while its enable bit is set.

The top bit of the normal status register is not a stored bit. It reads as one whenever any error status bit is set. Registers are reached through a plain port with separate write and read addresses, and reads return data combinationally.

Top module: `sdhc_irq_regs`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Normal status bits 0..7 hold these events: 0 command complete, 1 transfer complete, 2 block gap, 3 DMA, 4 buffer write ready, 5 buffer read ready, 6 card inserted, 7 card removed. A pulse on `ev_norm[i]` sets bit i at the next clock edge only when bit i of the normal status-enable register is one. Otherwise the pulse leaves no trace.
- R3: Error status bits 0..8 hold these events: 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 7 current limit, 8 auto-stop-command error. A pulse on `ev_err[i]` sets bit i at the next clock edge only when bit i of the error status-enable register is one.
- R4: Writing to status address 0 (normal) or 1 (error) clears every bit written as one and leaves every bit written as zero unchanged. Writing back a value just read acknowledges exactly the events in it.
- R5: When an enabled event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit is one afterwards.
- R6: Normal status bit 8 (card interrupt) equals `card_irq` AND enable bit 8, registered one cycle later. A write of one to it has no effect.
- R7: Normal status bit 15 reads as the OR of all error status bits. Writes to it have no effect, and it reads zero once all error bits are cleared.
- R8: Normal status reads with mask 0x81FF and error status with mask 0x01FF. The four enable registers store and return bits 8..0 only, and all other bits read zero.
- R9: `irq` is high exactly when some normal status bit 8..0 is set together with the same bit of the normal signal-enable register, or some error status bit is set together with the same bit of the error signal-enable register. Signal enables do not affect latching.
- R10: The address map is 0 normal status, 1 error status, 2 normal status-enable, 3 error status-enable, 4 normal signal-enable, 5 error signal-enable. Addresses 6 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | AW | Read register select |
| rd_data | output | 16 | Read data, combinational |
| ev_norm | input | 8 | Normal event pulses, bits 0..7 |
| ev_err | input | 9 | Error event pulses, bits 0..8 |
| card_irq | input | 1 | Card interrupt level |
| irq | output | 1 | Interrupt line, active high |

## Verification
A wrong status bit shows up on the next register read and on `irq` in the cycle after the edge that corrupted it. The bench therefore reads all eight addresses and compares `irq` after every clock edge, so a fault is caught within one cycle. A dropped enable gate appears as a stray bit after an event that should have been ignored. A broken clear shows as a bit that survives a write of ones.

// File: rtl/sdhc_irq_regs.sv
module sdhc_irq_regs #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  input  logic [7:0]    ev_norm,
  input  logic [8:0]    ev_err,
  input  logic          card_irq,
  output logic          irq
);
  localparam logic [AW-1:0] A_NST  = AW'(0);
  localparam logic [AW-1:0] A_EST  = AW'(1);
  localparam logic [AW-1:0] A_NEN  = AW'(2);
  localparam logic [AW-1:0] A_EEN  = AW'(3);
  localparam logic [AW-1:0] A_NSIG = AW'(4);
  localparam logic [AW-1:0] A_ESIG = AW'(5);

  logic [7:0] nst;
  logic       card_q;
  logic [8:0] est, nen, een, nsig, esig;

  wire [7:0] nclr = (wr_en && wr_addr == A_NST) ? wr_data[7:0] : 8'h0;
  wire [8:0] eclr = (wr_en && wr_addr == A_EST) ? wr_data[8:0] : 9'h0;
  wire [7:0] nset = ev_norm & nen[7:0];
  wire [8:0] eset = ev_err & een;
  wire       esum = |est;
  wire [8:0] nfull = {card_q, nst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nst <= '0; card_q <= 1'b0; est <= '0;
      nen <= '0; een <= '0; nsig <= '0; esig <= '0;
    end else begin
      nst    <= (nst & ~nclr) | nset;
      est    <= (est & ~eclr) | eset;
      card_q <= card_irq & nen[8];
      if (wr_en) begin
        case (wr_addr)
          A_NEN:   nen  <= wr_data[8:0];
          A_EEN:   een  <= wr_data[8:0];
          A_NSIG:  nsig <= wr_data[8:0];
          A_ESIG:  esig <= wr_data[8:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_NST:   rd_data = {esum, 6'b0, nfull};
      A_EST:   rd_data = {7'b0, est};
      A_NEN:   rd_data = {7'b0, nen};
      A_EEN:   rd_data = {7'b0, een};
      A_NSIG:  rd_data = {7'b0, nsig};
      A_ESIG:  rd_data = {7'b0, esig};
      default: rd_data = 16'h0;
    endcase
  end

  assign irq = (|(nfull & nsig)) | (|(est & esig));

  a_r2_no_stray_norm: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((nst & ~$past(nst) & ~$past(ev_norm & nen[7:0])) == 8'h0));

  a_r3_no_stray_err: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((est & ~$past(est) & ~$past(ev_err & een)) == 9'h0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_norm & nen[7:0])) |=> ((nst & $past(ev_norm & nen[7:0])) == $past(ev_norm & nen[7:0])));

  a_r4_clear_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_NST) |=> ((nst & $past(wr_data[7:0] & ~ev_norm)) == 8'h0));

  a_r9_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    (nsig == 9'h0 && esig == 9'h0) |-> !irq);
endmodule

// File: tb/sim_sdhc_irq_regs.sv
module sim_sdhc_irq_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [7:0] ev_norm = '0;
  logic [8:0] ev_err = '0;
  logic card_irq = 1'b0, irq;
  int total = 0, bad = 0;

  logic [7:0] m_nst = '0;
  logic m_card = 1'b0;
  logic [8:0] m_est = '0, m_nen = '0, m_een = '0, m_nsig = '0, m_esig = '0;

  always #10 clk = ~clk;

  sdhc_irq_regs #(.AW(3)) u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .rd_data, .ev_norm, .ev_err, .card_irq, .irq);

  function automatic logic [15:0] exp_rd(input int a);
    case (a)
      0: return {|m_est, 6'b0, m_card, m_nst};
      1: return {7'b0, m_est};
      2: return {7'b0, m_nen};
      3: return {7'b0, m_een};
      4: return {7'b0, m_nsig};
      5: return {7'b0, m_esig};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|({m_card, m_nst} & m_nsig)) | (|(m_est & m_esig));
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rd_addr = 3'(a);
    #1 v = rd_data;
  endtask

  task automatic check_all();
    logic [15:0] v;
    string tags[8] = '{"R4", "R3", "R8", "R8", "R8", "R8", "R10", "R10"};
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk(tags[a], v, exp_rd(a));
    end
    chk("R9", {15'b0, irq}, {15'b0, exp_irq()});
  endtask

  task automatic step(input logic w, input logic [2:0] wa, input logic [15:0] wd,
                      input logic [7:0] en_, input logic [8:0] ee, input logic c);
    logic [7:0] nclr;
    logic [8:0] eclr;
    wr_en = w; wr_addr = wa; wr_data = wd; ev_norm = en_; ev_err = ee; card_irq = c;
    nclr = (w && wa == 3'd0) ? wd[7:0] : 8'h0;
    eclr = (w && wa == 3'd1) ? wd[8:0] : 9'h0;
    @(posedge clk);
    #2;
    m_nst  = (m_nst & ~nclr) | (en_ & m_nen[7:0]);
    m_est  = (m_est & ~eclr) | (ee & m_een);
    m_card = c & m_nen[8];
    if (w) begin
      case (wa)
        3'd2: m_nen  = wd[8:0];
        3'd3: m_een  = wd[8:0];
        3'd4: m_nsig = wd[8:0];
        3'd5: m_esig = wd[8:0];
        default: ;
      endcase
    end
    wr_en = 1'b0; ev_norm = '0; ev_err = '0;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all();
    chk("R1", {15'b0, irq}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3: events with enables off leave nothing
    step(0, 0, 0, 8'hFF, 9'h1FF, 1'b1);
    rd(0, v); chk("R2", v, 16'h0);
    rd(1, v); chk("R3", v, 16'h0);
    step(1, 2, 16'hFFFF, 0, 0, 1'b1);
    step(1, 3, 16'hFFFF, 0, 0, 1'b1);
    rd(2, v); chk("R8", v, 16'h01FF);
    // R6: card level mirrored, W1C ignored
    rd(0, v); chk("R6", v, 16'h0100);
    step(1, 0, 16'h0100, 0, 0, 1'b1);
    rd(0, v); chk("R6", v, 16'h0100);
    step(0, 0, 0, 0, 0, 1'b0);
    rd(0, v); chk("R6", v, 16'h0000);
    // R2: enabled events latch
    step(0, 0, 0, 8'hA5, 0, 1'b0);
    rd(0, v); chk("R2", v, 16'h00A5);
    // R5: set wins over clear
    step(1, 0, 16'h00FF, 8'h01, 0, 1'b0);
    rd(0, v); chk("R5", v, 16'h0001);
    // R7: summary bit
    step(0, 0, 0, 0, 9'h100, 1'b0);
    rd(0, v); chk("R7", v, 16'h8001);
    step(1, 0, 16'h8000, 0, 0, 1'b0);
    rd(0, v); chk("R7", v, 16'h8001);
    step(1, 1, 16'h0100, 0, 0, 1'b0);
    rd(0, v); chk("R7", v, 16'h0001);
    // R9: signal enable gates line, not latching
    chk("R9", {15'b0, irq}, 16'h0);
    step(1, 4, 16'h0001, 0, 0, 1'b0);
    chk("R9", {15'b0, irq}, 16'h1);
    // R10: unmapped address writes ignored
    step(1, 6, 16'hFFFF, 0, 0, 1'b0);
    rd(6, v); chk("R10", v, 16'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] wa;
      logic [15:0] wd;
      logic w;
      wa = 3'($urandom % 8);
      w = ($urandom % 3) == 0;
      wd = 16'($urandom);
      if (wa < 3'd2 && ($urandom % 2) == 0) wd = exp_rd(int'(wa));
      step(w, wa, wd, 8'($urandom & $urandom & $urandom),
           9'($urandom & $urandom & $urandom), (i % 37) < 20);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule